// File: doc/BRIEF.md
# Frame-Locked Line Scrambler

This block whitens a byte-wide optical transport frame stream so that the far-end clock recovery sees enough transitions. It sits after the alignment overhead and the error-correction parity have been put into the stream. Each byte is XORed with the output of a 16-bit linear feedback shift register, and the register restarts from a fixed value at the same byte of every frame. The keystream therefore depends only on the position in the frame and not on the data.

The frame-start strobe marks the first byte of a frame. The leading alignment bytes are sent in the clear and do not move the register. The register is loaded at the byte that follows them, and that byte is the first one scrambled. Every later byte is scrambled until the next strobe. The scrambled byte and the strobe leave through one register stage. XOR with the same keystream undoes itself, so a second copy of the block with the same framing restores the original stream.

Top module: `line_scrambler`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `scr_data` is 0x00 and `scr_fstart` is 0. Reset is synchronous and active high.
- R2: Each output byte and `scr_fstart` appear exactly one clock after the matching input byte and `fstart`.
- R3: After reset, and until the first `fstart` is seen, every byte passes through unchanged.
- R4: The byte sampled with `fstart` high and the next OH_BYTES-1 bytes (six in all by default) leave unchanged and do not advance the register.
- R5: The byte at 0-based offset OH_BYTES from `fstart` (the seventh) is scrambled with a register freshly loaded with 0xFFFF. The first keystream bit produced goes to data bit 7 and the last to bit 0.
- R6: Each keystream bit is state bit 15, after which the state shifts left and takes s15^s14^s12^s3 into bit 0 (generator 1 + x + x^3 + x^12 + x^16). Eight bits are used per byte, and later bytes continue the sequence.
- R7: Every `fstart` restarts the overhead count and the reload, including a strobe that arrives before the previous frame has reached its seventh byte or after a frame of any length.
- R8: Within one frame of continuous scrambled bytes, the keystream byte at scrambled offset k equals the one at offset k+65535.
- R9: Feeding `scr_data` and `scr_fstart` into a second instance gives back the original bytes two clocks after they entered the first instance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line byte clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 8 | Frame byte, overhead and parity already present |
| fstart | input | 1 | High on the first byte of each frame |
| scr_data | output | 8 | Registered, scrambled byte |
| scr_fstart | output | 1 | `fstart` delayed to line up with `scr_data` |

## Verification
The hardest condition to reach is the wrap of the keystream. It only shows after 65535 scrambled bytes with no new frame start, so the stimulus opens one very long frame of zero bytes. It records the first keystream bytes and compares them with the bytes exactly 65535 positions later. Early reloads are reached by putting a strobe into the middle of the overhead and into a short frame. The inverse property is tested by chaining a second instance behind the first on a patterned stream that crosses several frame boundaries.

// File: rtl/line_scrambler_pkg.sv
package line_scrambler_pkg;

  // Role of the byte currently at the input
  typedef enum logic [1:0] {
    POS_UNSYNCED = 2'd0,  // no frame start seen since reset
    POS_CLEAR    = 2'd1,  // alignment overhead, bypassed
    POS_SEED     = 2'd2,  // first scrambled byte, register reloaded
    POS_RUN      = 2'd3   // scrambled, register continues
  } pos_class_e;

endpackage

// File: rtl/scr_frame_tracker.sv
module scr_frame_tracker
  import line_scrambler_pkg::*;
#(
  parameter int OH_BYTES = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fstart,
  output pos_class_e cls
);

  localparam int PW = $clog2(OH_BYTES + 2);
  localparam logic [PW-1:0] OH_IDX   = PW'(OH_BYTES);
  localparam logic [PW-1:0] LAST_IDX = PW'(OH_BYTES + 1);

  logic [PW-1:0] pos_q;
  logic          sync_q;
  logic [PW-1:0] idx;
  logic [PW-1:0] idx_next;

  assign idx      = fstart ? '0 : pos_q;
  assign idx_next = (idx == LAST_IDX) ? idx : idx + 1'b1;

  always_comb begin
    if (!fstart && !sync_q)   cls = POS_UNSYNCED;
    else if (idx < OH_IDX)    cls = POS_CLEAR;
    else if (idx == OH_IDX)   cls = POS_SEED;
    else                      cls = POS_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      sync_q <= 1'b0;
    end else if (fstart || sync_q) begin
      pos_q  <= idx_next;
      sync_q <= 1'b1;
    end
  end

endmodule

// File: rtl/scr_keystream.sv
module scr_keystream #(
  parameter int              LFSR_W = 16,
  parameter int              DATA_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 16'hD008,
  parameter logic [LFSR_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  output logic [DATA_W-1:0] ks,
  output logic [LFSR_W-1:0] state_q
);

  logic [LFSR_W-1:0] chain [DATA_W+1];

  assign chain[0] = load ? SEED : state_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign ks[DATA_W-1-i] = chain[i][LFSR_W-1];
    assign chain[i+1]     = {chain[i][LFSR_W-2:0], ^(chain[i] & TAPS)};
  end

  always_ff @(posedge clk) begin
    if (rst)              state_q <= SEED;
    else if (load || adv) state_q <= chain[DATA_W];
  end

endmodule

// File: rtl/scr_out_stage.sv
module scr_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] ks,
  input  logic              scramble,
  input  logic              fs_in,
  output logic [DATA_W-1:0] dout,
  output logic              fs_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      fs_out <= 1'b0;
    end else begin
      dout   <= scramble ? (din ^ ks) : din;
      fs_out <= fs_in;
    end
  end

endmodule

// File: rtl/line_scrambler.sv
module line_scrambler
  import line_scrambler_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                LFSR_W   = 16,
  parameter int                OH_BYTES = 6,
  parameter logic [LFSR_W-1:0] TAPS     = 16'hD008,
  parameter logic [LFSR_W-1:0] SEED     = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic              fstart,
  output logic [DATA_W-1:0] scr_data,
  output logic              scr_fstart
);

  pos_class_e        cls;
  logic [DATA_W-1:0] ks;
  logic [LFSR_W-1:0] ks_state;
  logic              ks_load;
  logic              ks_adv;

  assign ks_load = (cls == POS_SEED);
  assign ks_adv  = (cls == POS_RUN);

  scr_frame_tracker #(.OH_BYTES(OH_BYTES)) u_track (
    .clk    (clk),
    .rst    (rst),
    .fstart (fstart),
    .cls    (cls)
  );

  scr_keystream #(
    .LFSR_W (LFSR_W),
    .DATA_W (DATA_W),
    .TAPS   (TAPS),
    .SEED   (SEED)
  ) u_ks (
    .clk     (clk),
    .rst     (rst),
    .load    (ks_load),
    .adv     (ks_adv),
    .ks      (ks),
    .state_q (ks_state)
  );

  scr_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .din      (data_in),
    .ks       (ks),
    .scramble (ks_load || ks_adv),
    .fs_in    (fstart),
    .dout     (scr_data),
    .fs_out   (scr_fstart)
  );

endmodule

// File: rtl/line_scrambler_checker.sv
module line_scrambler_checker #(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] data_in,
  input logic              fstart,
  input logic [DATA_W-1:0] scr_data,
  input logic              scr_fstart,
  input logic [LFSR_W-1:0] ks_state
);

  logic prev_rst;
  logic seen_fs;

  always_ff @(posedge clk) begin
    prev_rst <= rst;
    if (rst)         seen_fs <= 1'b0;
    else if (fstart) seen_fs <= 1'b1;
  end

  // R1: outputs are cleared on the first cycle out of reset
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    prev_rst |-> (scr_data == '0 && !scr_fstart));

  // R2: strobe is delayed by exactly one clock
  assert_fs_delay_R2: assert property (@(posedge clk) disable iff (rst)
    !prev_rst |-> (scr_fstart == $past(fstart)));

  // R3: no frame seen yet, so data is passed in the clear
  assert_unsynced_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && !seen_fs) |-> (scr_data == $past(data_in)));

  // R4: the frame-start byte itself is never scrambled
  assert_fs_byte_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && scr_fstart) |-> (scr_data == $past(data_in)));

  // R6: the register never falls into the all-zero lock state
  assert_state_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    ks_state != '0);

endmodule

bind line_scrambler line_scrambler_checker #(
  .DATA_W (DATA_W),
  .LFSR_W (LFSR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .data_in    (data_in),
  .fstart     (fstart),
  .scr_data   (scr_data),
  .scr_fstart (scr_fstart),
  .ks_state   (ks_state)
);

// File: tb/line_scrambler_tb.sv
module line_scrambler_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic       fstart = 1'b0;
  logic [7:0] scr_data;
  logic       scr_fstart;
  logic [7:0] back_data;
  logic       back_fstart;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  line_scrambler u_dut (
    .clk(clk), .rst(rst), .data_in(data_in), .fstart(fstart),
    .scr_data(scr_data), .scr_fstart(scr_fstart)
  );

  // R9: second instance for the loopback check
  line_scrambler u_back (
    .clk(clk), .rst(rst), .data_in(scr_data), .fstart(scr_fstart),
    .scr_data(back_data), .scr_fstart(back_fstart)
  );

  // Keystream byte at scrambled offset k, from seed 0xFFFF (R5, R6)
  function automatic logic [7:0] ks_at(input int k);
    logic [15:0] s = 16'hFFFF;
    logic [7:0]  b = '0;
    for (int n = 0; n < 8 * k + 8; n++) begin
      if (n >= 8 * k) b[7 - (n - 8 * k)] = s[15];
      s = {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Pipelined driver: checks the previous byte's output, then applies a new byte
  logic       pend = 1'b0;
  logic [7:0] pend_b;
  logic       pend_fs;
  string      pend_req;
  logic [7:0] obs;
  logic [7:0] back_obs;

  task automatic drive(input logic fs, input logic [7:0] d, input bit chk,
                       input logic [7:0] eb, input string req);
    @(negedge clk);
    obs      = scr_data;
    back_obs = back_data;
    if (pend) begin
      check(scr_data == pend_b, pend_req, scr_data, pend_b);
      check(scr_fstart == pend_fs, "R2", scr_fstart, pend_fs);
    end
    fstart = fs; data_in = d;
    pend = chk; pend_b = eb; pend_fs = fs; pend_req = req;
  endtask

  // Stimulus table: fs, data, scrambled?, keystream offset
  typedef struct packed {
    logic       fs;
    logic [7:0] d;
    logic       scr;
    logic [7:0] k;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    // frame A: 6 clear overhead bytes (R4), then seed (R5) and run (R6)
    '{1'b1, 8'hF6, 1'b0, 8'd0}, '{1'b0, 8'hF6, 1'b0, 8'd0},
    '{1'b0, 8'hF6, 1'b0, 8'd0}, '{1'b0, 8'h28, 1'b0, 8'd0},
    '{1'b0, 8'h28, 1'b0, 8'd0}, '{1'b0, 8'h28, 1'b0, 8'd0},
    '{1'b0, 8'h00, 1'b1, 8'd0}, '{1'b0, 8'h00, 1'b1, 8'd1},
    '{1'b0, 8'h00, 1'b1, 8'd2}, '{1'b0, 8'h00, 1'b1, 8'd3},
    '{1'b0, 8'hFF, 1'b1, 8'd4}, '{1'b0, 8'h5A, 1'b1, 8'd5},
    '{1'b0, 8'h81, 1'b1, 8'd6}, '{1'b0, 8'h3C, 1'b1, 8'd7},
    // frame B: strobe arrives inside the overhead, restarts it (R7)
    '{1'b1, 8'h11, 1'b0, 8'd0}, '{1'b0, 8'h22, 1'b0, 8'd0},
    '{1'b0, 8'h33, 1'b0, 8'd0},
    // frame C: full overhead then short payload (R7)
    '{1'b1, 8'h44, 1'b0, 8'd0}, '{1'b0, 8'h55, 1'b0, 8'd0},
    '{1'b0, 8'h66, 1'b0, 8'd0}, '{1'b0, 8'h77, 1'b0, 8'd0},
    '{1'b0, 8'h88, 1'b0, 8'd0}, '{1'b0, 8'h99, 1'b0, 8'd0},
    '{1'b0, 8'hFF, 1'b1, 8'd0}, '{1'b0, 8'hFF, 1'b1, 8'd1},
    '{1'b0, 8'hFF, 1'b1, 8'd2},
    // frame D: reload after a short frame gives the same keystream (R7)
    '{1'b1, 8'hA0, 1'b0, 8'd0}, '{1'b0, 8'hA1, 1'b0, 8'd0},
    '{1'b0, 8'hA2, 1'b0, 8'd0}, '{1'b0, 8'hA3, 1'b0, 8'd0},
    '{1'b0, 8'hA4, 1'b0, 8'd0}, '{1'b0, 8'hA5, 1'b0, 8'd0},
    '{1'b0, 8'h0F, 1'b1, 8'd0}, '{1'b0, 8'hF0, 1'b1, 8'd1}
  };

  logic [7:0] head [8];
  logic [7:0] hist0, hist1;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(scr_data == 8'h00, "R1", scr_data, 0);
    check(scr_fstart == 1'b0, "R1", scr_fstart, 0);
    rst = 1'b0;
    @(negedge clk);
    check(scr_data == 8'h00 && !scr_fstart, "R1", scr_data, 0);

    // R3: bytes before any frame start pass unchanged
    for (int i = 0; i < 5; i++) drive(1'b0, 8'hC3 + 8'(i), 1'b1, 8'hC3 + 8'(i), "R3");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      string r;
      logic [7:0] e;
      if (!VEC[i].scr) begin r = "R4"; e = VEC[i].d; end
      else begin
        r = (i >= 23) ? "R7" : ((VEC[i].k == 0) ? "R5" : "R6");
        e = VEC[i].d ^ ks_at(int'(VEC[i].k));
      end
      drive(VEC[i].fs, VEC[i].d, 1'b1, e, r);
    end

    // R8: one long frame of zeros, keystream wraps after 65535 bytes
    for (int i = 0; i < 6; i++) drive(i == 0, 8'h00, 1'b1, 8'h00, "R4");
    for (int i = 0; i < 65535 + 9; i++) begin
      drive(1'b0, 8'h00, 1'b0, 8'h00, "R8");
      if (i >= 1 && i <= 8) head[i-1] = obs;
      if (i >= 65536 && i <= 65543)
        check(obs == head[i-65536], "R8", obs, head[i-65536]);
    end
    check(head[0] == ks_at(0) && head[2] == ks_at(2), "R8", head[2], ks_at(2));

    // R9: loopback through a second instance restores the data
    hist0 = 8'h00; hist1 = 8'h00;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] d = 8'(i * 37 + 5);
      drive((i % 15) == 0, d, 1'b0, 8'h00, "R9");
      if (i >= 2) check(back_obs == hist1, "R9", back_obs, hist1);
      hist1 = hist0; hist0 = d;
    end

    // R1 and R3: reset in mid-frame, then unsynced bytes pass in clear
    @(negedge clk); rst = 1'b1; pend = 1'b0; data_in = 8'h5E;
    @(negedge clk);
    @(negedge clk);
    check(scr_data == 8'h00 && !scr_fstart, "R1", scr_data, 0);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) drive(1'b0, 8'h90 + 8'(i), 1'b1, 8'h90 + 8'(i), "R3");
    drive(1'b0, 8'h00, 1'b0, 8'h00, "");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule